// File: doc/BRIEF.md
# Streaming Per-Node 3x3 Stencil Engine

This block evaluates a banded matrix-vector product r = A·v on a two-dimensional grid of WIDTH columns by HEIGHT rows. Each result is a weighted sum of the nine values in the 3x3 neighbourhood around a node. Every node carries its own nine weights, so the operation is a sparse matrix-vector product and not a fixed image filter.

The vector v enters as a raster-ordered stream, one sample per accepted cycle, with a valid/ready handshake. The node's nine weights travel with the sample on a parallel port. A start-of-frame flag marks the first sample of each grid.

Internally the stream is delayed through a tap line of two rows plus three samples. The weights are held back until their node sits at the window centre. The nine signed products are summed in parallel. Results leave in raster order with a flag on the final node. After the last sample of a grid, the block drains the remaining results by itself.

Top module: `stencil3x3`

## Requirements
- R1: For the node at column x and row y, out_data equals the sum over row offset yo and column offset xo, each in {-1,0,1}, of coefficient k times v(x+xo, y+yo). Coefficient k = (yo+1)*3 + (xo+1) occupies in_coef bits [k*CW +: CW] of the beat that carries the sample of node (x,y).
- R2: Each node uses only the weights delivered with its own sample. Weights differ from node to node.
- R3: Samples are consumed and results are produced in raster order: column inner, row outer. Exactly WIDTH*HEIGHT results leave per frame, and nothing more.
- R4: A neighbour outside the grid (x+xo or y+yo out of range) contributes zero. This also holds for grids with WIDTH or HEIGHT equal to 1.
- R5: Data (DW bits) and weights (CW bits) are two's-complement signed. The DW+CW+4 bit result is exact, including when every operand holds its most negative value.
- R6: With in_valid and out_ready held high, out_valid stays high for WIDTH*HEIGHT consecutive cycles, one result per cycle.
- R7: The result for node n becomes valid in the cycle after the edge that accepts sample n+WIDTH+1. The first result of a continuously fed frame therefore appears WIDTH+1 cycles after the acceptance edge of its first sample.
- R8: A sample with in_sof set is taken as node 0. out_last is high only on the final node of a frame. After the final sample is accepted, in_ready stays low for WIDTH+1 drain cycles when out_ready is high.
- R9: While out_valid is high and out_ready is low, the output holds its data and last flag, in_ready is low, and no sample is lost or repeated.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| in_sof | input | 1 | Sample is node 0 of a new frame |
| in_data | input | DW | Signed vector sample |
| in_coef | input | 9*CW | Nine signed weights of the node |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream accepts the result |
| out_last | output | 1 | Result is the final node of the frame |
| out_data | output | DW+CW+4 | Signed weighted sum |

## Verification
A downstream stall can arrive in the same cycle as the internal drain of a frame's last rows, or while the next frame's first sample is already waiting. The bench provokes this by sending frames back to back under random out_ready and gapped in_valid. Each streamed result is compared against a direct nine-term sum computed in the bench. The bench also checks that results held under a stall do not change, and that each frame yields exactly its node count with the last flag in place.

// File: rtl/stencil3x3.sv
module stencil3x3 #(
  parameter int WIDTH  = 8,
  parameter int HEIGHT = 6,
  parameter int DW     = 12,
  parameter int CW     = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_sof,
  input  logic signed [DW-1:0]        in_data,
  input  logic        [9*CW-1:0]      in_coef,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        out_last,
  output logic signed [DW+CW+3:0]     out_data
);
  localparam int AW   = DW + CW + 4;
  localparam int N    = WIDTH * HEIGHT;
  localparam int TAPS = 2 * WIDTH + 3;
  localparam int CD   = WIDTH + 2;
  localparam int IW   = $clog2(N + WIDTH + 2);
  localparam int XW   = $clog2(WIDTH + 1);
  localparam int YW   = $clog2(HEIGHT + 1);

  logic signed [DW-1:0]   sr [TAPS];
  logic        [9*CW-1:0] cr [CD];
  logic [IW-1:0] cnt;
  logic          flushing, cv, clast;
  logic [XW-1:0] ccx;
  logic [YW-1:0] ccy;
  logic signed [AW-1:0] acc;

  wire          can_step = !cv || out_ready;
  wire          step     = can_step && (flushing || in_valid);
  wire [IW-1:0] inow     = (!flushing && in_sof) ? '0 : cnt;

  assign in_ready  = can_step && !flushing;
  assign out_valid = cv;
  assign out_last  = clast;
  assign out_data  = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; flushing <= 1'b0; cv <= 1'b0; clast <= 1'b0;
      ccx <= '0; ccy <= '0;
    end else if (step) begin
      if (inow == IW'(N + WIDTH)) begin
        cnt <= '0;
        flushing <= 1'b0;
      end else begin
        cnt <= inow + 1'b1;
        if (inow == IW'(N - 1)) flushing <= 1'b1;
      end
      cv    <= inow >= IW'(WIDTH + 1);
      clast <= inow == IW'(N + WIDTH);
      if (inow == IW'(WIDTH + 1)) begin
        ccx <= '0; ccy <= '0;
      end else if (ccx == XW'(WIDTH - 1)) begin
        ccx <= '0; ccy <= ccy + 1'b1;
      end else begin
        ccx <= ccx + 1'b1;
      end
    end else if (out_ready) begin
      cv <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      sr[0] <= flushing ? '0 : in_data;
      cr[0] <= flushing ? '0 : in_coef;
      for (int t = 1; t < TAPS; t++) sr[t] <= sr[t-1];
      for (int t = 1; t < CD; t++)   cr[t] <= cr[t-1];
    end
  end

  always_comb begin
    acc = '0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        if ((r != 0 || ccy != '0) && (r != 2 || ccy != YW'(HEIGHT - 1)) &&
            (c != 0 || ccx != '0) && (c != 2 || ccx != XW'(WIDTH - 1)))
          acc = acc + AW'(sr[(2 - r) * WIDTH + 2 - c]) *
                      AW'($signed(cr[CD-1][(r * 3 + c) * CW +: CW]));
  end
endmodule

// File: rtl/stencil3x3_chk.sv
module stencil3x3_chk #(
  parameter int WIDTH  = 8,
  parameter int HEIGHT = 6,
  parameter int AW     = 26
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_last,
  input logic [AW-1:0] out_data
);
  localparam int N = WIDTH * HEIGHT;
  int oc;

  always_ff @(posedge clk) begin
    if (rst) oc <= 0;
    else if (out_valid && out_ready) oc <= out_last ? 0 : oc + 1;
  end

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R9
  in_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R8
  last_gap_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last && out_ready |=> !out_valid);

  // R3
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> oc == N - 1);
endmodule

bind stencil3x3 stencil3x3_chk #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .AW(DW + CW + 4)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_data(out_data));

// File: tb/stencil_lane.sv
module stencil_lane #(
  parameter int W  = 5,
  parameter int H  = 4,
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic clk,
  input  logic rst,
  output int   total,
  output int   bad,
  output logic done
);
  localparam int N  = W * H;
  localparam int AW = DW + CW + 4;
  localparam int F  = 4;

  logic in_valid, in_ready, in_sof, out_valid, out_ready, out_last;
  logic signed [DW-1:0] in_data;
  logic [9*CW-1:0] in_coef;
  logic signed [AW-1:0] out_data;

  stencil3x3 #(.WIDTH(W), .HEIGHT(H), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_data(in_data), .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .out_data(out_data));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vv [F][N];
  int cc [F][N][9];
  int mframe = 0;
  int e0, e_last, e_next, first_out, last_out;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s lane %0dx%0d actual=%0d expected=%0d", tag, W, H, act, exp);
    end
  endtask

  function automatic longint refv(input int f, input int idx);
    longint s = 0;
    int x = idx % W, y = idx / W;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        int nx = x + c - 1, ny = y + r - 1;
        if (nx >= 0 && nx < W && ny >= 0 && ny < H)
          s += longint'(cc[f][idx][r*3+c]) * longint'(vv[f][ny*W+nx]);
      end
    return s;
  endfunction

  initial begin
    out_ready = 1'b0;
    wait (!rst);
    forever begin
      @(posedge clk); #5;
      if (mframe < 2) out_ready = 1'b1;
      else if (mframe == 2) out_ready = 1'($urandom_range(0, 1));
      else out_ready = ($urandom_range(0, 3) == 0);
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_data = '0; in_coef = '0;
    // R2: every node receives its own random weights
    for (int f = 0; f < F; f++)
      for (int i = 0; i < N; i++) begin
        vv[f][i] = (f == 3) ? -(2 ** (DW-1)) : int'($urandom_range(0, 2**DW - 1)) - 2 ** (DW-1);
        for (int k = 0; k < 9; k++)
          cc[f][i][k] = (f == 3) ? -(2 ** (CW-1)) : int'($urandom_range(0, 2**CW - 1)) - 2 ** (CW-1);
      end
    wait (!rst);
    @(negedge clk); #5;
    chk(!out_valid, "R10 out_valid", longint'(out_valid), 0);
    chk(in_ready, "R10 in_ready", longint'(in_ready), 1);
    @(posedge clk); #5;
    fork
      begin
        for (int f = 0; f < F; f++)
          for (int i = 0; i < N; i++) begin
            bit ok;
            if (f == 2 && $urandom_range(0, 2) == 0) begin
              in_valid = 1'b0;
              @(posedge clk); #5;
            end
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_data  = DW'(vv[f][i]);
            for (int k = 0; k < 9; k++) in_coef[k*CW +: CW] = CW'(cc[f][i][k]);
            do begin
              @(negedge clk); #5;
              ok = in_ready;
              if (ok && f == 0 && i == 0)     e0     = cyc + 1;
              if (ok && f == 0 && i == N - 1) e_last = cyc + 1;
              if (ok && f == 1 && i == 0)     e_next = cyc + 1;
              @(posedge clk); #5;
            end while (!ok);
          end
        in_valid = 1'b0;
        in_sof = 1'b0;
      end
      begin
        bit stl = 0;
        logic signed [AW-1:0] hd = '0;
        logic hl = 1'b0;
        for (int f = 0; f < F; f++) begin
          mframe = f;
          for (int i = 0; i < N; i++) begin
            int x = i % W, y = i / W;
            string tag;
            do begin
              @(negedge clk); #5;
              if (stl) chk(out_valid && out_data == hd && out_last == hl, "R9 hold",
                           longint'(out_data), longint'(hd));
              stl = out_valid && !out_ready;
              hd = out_data;
              hl = out_last;
            end while (!(out_valid && out_ready));
            stl = 0;
            if (f == 0 && i == 0)     first_out = cyc;
            if (f == 0 && i == N - 1) last_out  = cyc;
            if (f == 3) tag = "R5 extreme";
            else if (x == 0 || x == W-1 || y == 0 || y == H-1) tag = "R4 boundary";
            else if (f == 1) tag = "R2 per-node";
            else tag = "R1 sum";
            chk(longint'(out_data) == refv(f, i), tag, longint'(out_data), refv(f, i));
            chk(out_last == (i == N - 1), "R8 last flag", longint'(out_last), longint'(i == N - 1));
          end
        end
        chk(first_out - e0 == W + 1, "R7 latency", first_out - e0, W + 1);
        chk(last_out - first_out == N - 1, "R6 throughput", last_out - first_out, N - 1);
        chk(e_next - e_last == W + 2, "R8 drain", e_next - e_last, W + 2);
        repeat (3 * W + 10) begin
          @(negedge clk); #5;
          if (out_valid) chk(0, "R3 extra output", 1, 0);
        end
        chk(!out_valid, "R3 idle", longint'(out_valid), 0);
      end
    join
    done = 1'b1;
  end
endmodule

// File: tb/sim_stencil3x3.sv
module sim_stencil3x3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int t0, t1, t2, b0, b1, b2;
  logic d0, d1, d2;

  stencil_lane #(.W(5), .H(4)) u0 (.clk(clk), .rst(rst), .total(t0), .bad(b0), .done(d0));
  stencil_lane #(.W(1), .H(4)) u1 (.clk(clk), .rst(rst), .total(t1), .bad(b1), .done(d1));
  stencil_lane #(.W(6), .H(1)) u2 (.clk(clk), .rst(rst), .total(t2), .bad(b2), .done(d2));

  initial begin
    int tot, nbad;
    bit wd = 0;
    repeat (4) @(posedge clk);
    #5 rst = 1'b0;
    fork
      wait (d0 && d1 && d2);
      begin
        repeat (100000) @(posedge clk);
        wd = 1;
      end
    join_any
    tot  = t0 + t1 + t2;
    nbad = b0 + b1 + b2;
    if (wd) begin
      tot++;
      nbad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", tot, nbad);
    $finish;
  end
endmodule